// File: doc/BRIEF.md
# Bus-Attached Two-Slice Arithmetic/Logic Unit

This block is an 8-bit arithmetic and logic unit that hangs off a shared system data bus. Two operands are taken from the bus, each into its own holding register. Each register has its own load strobe and shares an asynchronous active-low clear. The datapath is two 4-bit slices. The carry ripples from the low slice into the high slice.

Every slice decodes a 4-bit function code and a mode bit. In logic mode it computes one of sixteen bitwise functions. In arithmetic mode it computes one of sixteen sums. The carry input and the carry output both use an active-low convention: a carry input of 1 means "no carry". The result leaves the block as a data value plus a separate drive enable, which stand in for a tri-state bus driver. A bus master loads the operands over two cycles, sets the function and carry lines, and raises the drive enable in the cycle where it wants the result on the bus.

Top module: `alu_bus_unit`

## Requirements
- R1: On a rising clock edge with `ld_a` high, operand A takes the value of `bus_in`. With `ld_a` low, operand A keeps its value. Operand B behaves the same way under `ld_b`.
- R2: While `rst_n` is low, both operand registers are cleared to zero at once, without waiting for a clock edge.
- R3: With `mode_logic`=1, the result F is a bitwise function of A and B selected by `fsel`: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R4: With `mode_logic`=1, `cin_n` has no effect on the result, and `cout_n` reads 1.
- R5: With `mode_logic`=0 and `fsel`=1001, F = A + B + c modulo 256, where c = NOT `cin_n`. `cout_n` is the inverse of the carry out of bit 7.
- R6: With `mode_logic`=0 and `fsel`=0110, F = A + ~B + c, that is A − B − 1 + c. With `cin_n`=0 this is A − B, and `cout_n`=0 exactly when A ≥ B.
- R7: The other arithmetic codes compute X + Y + c, with `cout_n` inverted as in R5:
  - 0000: X=A, Y=0
  - 0001: X=A|B, Y=0
  - 0010: X=A|~B, Y=0
  - 0011: X=0, Y=FF
  - 0100: X=A, Y=A&~B
  - 0101: X=A|B, Y=A&~B
  - 0111: X=A&~B, Y=FF
  - 1000: X=A, Y=A&B
  - 1010: X=A|~B, Y=A&B
  - 1011: X=A&B, Y=FF
  - 1100: X=A, Y=A
  - 1101: X=A|B, Y=A
  - 1110: X=A|~B, Y=A
  - 1111: X=A, Y=FF
- R8: A carry produced in the low nibble reaches the high nibble. For example, 0F + 01 gives 10, and FF + 01 with no carry-in gives 00 with `cout_n`=0.
- R9: `bus_oe` equals `drive_en`. `bus_out` equals F while `drive_en` is high and is 00 while it is low. `cout_n` does not depend on `drive_en`.
- R10: `bus_out` and `cout_n` follow changes of `fsel`, `mode_logic`, `cin_n` and `drive_en` within the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the operand registers |
| rst_n | input | 1 | Asynchronous active-low clear of both operands |
| bus_in | input | 8 | Value currently on the system bus |
| ld_a | input | 1 | Load strobe for operand A |
| ld_b | input | 1 | Load strobe for operand B |
| fsel | input | 4 | Function code |
| mode_logic | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| cin_n | input | 1 | Active-low carry into the low slice |
| drive_en | input | 1 | Request to drive the result onto the bus |
| bus_out | output | 8 | Result value offered to the bus (00 when not driving) |
| bus_oe | output | 1 | Bus driver enable |
| cout_n | output | 1 | Active-low carry out of the high slice |

## Verification
The bench first fixes one operand pair with mixed bit patterns. With that pair it sweeps all sixteen codes in both modes and under both carry-in levels. This separates the individual functions from one another and shows that the carry line counts only in arithmetic mode. Boundary pairs then exercise the carry path: 0F+01 needs the carry to cross the nibble boundary, FF+01 overflows out of bit 7, and subtraction is run with A below, equal to and above B to cover both borrow outcomes. Load-hold steps, a mid-cycle clear, steps with the driver off, and a long run of random operands and controls check operand capture, the clear and output gating against the same reference.

// File: rtl/alu_bus_pkg.sv
package alu_bus_pkg;

    localparam int DATA_W  = 8;
    localparam int SLICE_W = 4;

    localparam logic [3:0] FN_SUM      = 4'b1001;
    localparam logic [3:0] FN_DIFF     = 4'b0110;
    localparam logic [3:0] FN_PASS_A   = 4'b1111;
    localparam logic [3:0] FN_PASS_B   = 4'b1010;

endpackage

// File: rtl/alu_slice.sv
module alu_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   s,
    input  logic         m,
    input  logic         cin_n,
    output logic [W-1:0] f,
    output logic         cout_n
);

    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic [W-1:0] lf;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W:0]   sum;

    // Logic functions
    always_comb begin
        unique case (s)
            4'b0000: lf = ~a;
            4'b0001: lf = ~(a | b);
            4'b0010: lf = ~a & b;
            4'b0011: lf = '0;
            4'b0100: lf = ~(a & b);
            4'b0101: lf = ~b;
            4'b0110: lf = a ^ b;
            4'b0111: lf = a & ~b;
            4'b1000: lf = ~a | b;
            4'b1001: lf = ~(a ^ b);
            4'b1010: lf = b;
            4'b1011: lf = a & b;
            4'b1100: lf = ONES;
            4'b1101: lf = a | ~b;
            4'b1110: lf = a | b;
            default: lf = a;
        endcase
    end

    // Arithmetic: two addend terms picked by the code, then one adder
    always_comb begin
        unique case (s)
            4'b0000: begin x = a;       y = '0;      end
            4'b0001: begin x = a | b;   y = '0;      end
            4'b0010: begin x = a | ~b;  y = '0;      end
            4'b0011: begin x = '0;      y = ONES;    end
            4'b0100: begin x = a;       y = a & ~b;  end
            4'b0101: begin x = a | b;   y = a & ~b;  end
            4'b0110: begin x = a;       y = ~b;      end
            4'b0111: begin x = a & ~b;  y = ONES;    end
            4'b1000: begin x = a;       y = a & b;   end
            4'b1001: begin x = a;       y = b;       end
            4'b1010: begin x = a | ~b;  y = a & b;   end
            4'b1011: begin x = a & b;   y = ONES;    end
            4'b1100: begin x = a;       y = a;       end
            4'b1101: begin x = a | b;   y = a;       end
            4'b1110: begin x = a | ~b;  y = a;       end
            default: begin x = a;       y = ONES;    end
        endcase
        sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ~cin_n};
    end

    always_comb begin
        f      = m ? lf : sum[W-1:0];
        cout_n = m ? 1'b1 : ~sum[W];
    end

endmodule

// File: rtl/alu_operand_regs.sv
module alu_operand_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic         ld_a,
    input  logic         ld_b,
    output logic [W-1:0] opa,
    output logic [W-1:0] opb
);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } opnd_t;

    opnd_t st_d;
    opnd_t st_q;

    always_comb begin
        st_d = st_q;
        if (ld_a) st_d.a = bus_in;
        if (ld_b) st_d.b = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opa = st_q.a;
    assign opb = st_q.b;

    p_load_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a |=> opa == $past(bus_in));
    p_load_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_b |=> opb == $past(bus_in));
    p_hold_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a |=> $stable(opa));
    p_hold_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_b |=> $stable(opb));

endmodule

// File: rtl/alu_bus_unit.sv
module alu_bus_unit
    import alu_bus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SLICE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_in,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic [3:0]    fsel,
    input  logic          mode_logic,
    input  logic          cin_n,
    input  logic          drive_en,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          cout_n
);

    localparam int NSL = DW / SW;

    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [DW-1:0] res;
    logic [NSL:0]  cn_chain;

    alu_operand_regs #(.W(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_in (bus_in),
        .ld_a   (ld_a),
        .ld_b   (ld_b),
        .opa    (opa),
        .opb    (opb)
    );

    assign cn_chain[0] = cin_n;

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        alu_slice #(.W(SW)) u_slice (
            .a      (opa[g*SW +: SW]),
            .b      (opb[g*SW +: SW]),
            .s      (fsel),
            .m      (mode_logic),
            .cin_n  (cn_chain[g]),
            .f      (res[g*SW +: SW]),
            .cout_n (cn_chain[g+1])
        );
    end

    assign bus_out = drive_en ? res : '0;
    assign bus_oe  = drive_en;
    assign cout_n  = cn_chain[NSL];

    p_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_logic && fsel == FN_SUM) |->
        {~cout_n, res} == ({1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, ~cin_n}));
    p_diff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_logic && fsel == FN_DIFF) |->
        {~cout_n, res} == ({1'b0, opa} + {1'b0, ~opb} + {{DW{1'b0}}, ~cin_n}));
    p_logic_cout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_logic |-> cout_n);
    p_pass_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_logic && fsel == FN_PASS_B) |-> res == opb);

endmodule

// File: tb/alu_bus_unit_bench.sv
`timescale 1ns/1ps
module alu_bus_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = '0;
    logic       ld_a = 1'b0, ld_b = 1'b0;
    logic [3:0] fsel = '0;
    logic       mode_logic = 1'b1;
    logic       cin_n = 1'b1;
    logic       drive_en = 1'b0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       cout_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] ma = '0, mb = '0;

    always #2.5 clk = ~clk;

    alu_bus_unit u_alu_bus_unit (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
        .fsel(fsel), .mode_logic(mode_logic), .cin_n(cin_n), .drive_en(drive_en),
        .bus_out(bus_out), .bus_oe(bus_oe), .cout_n(cout_n)
    );

    // Reference result: returns {cout_n, F}
    function automatic logic [8:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                           input logic [3:0] s, input logic m,
                                           input logic cn);
        logic [7:0] x, y;
        int total;
        if (m) begin
            case (s)
                0: x = ~a;          1: x = ~(a | b);   2: x = ~a & b;   3: x = 8'h00;
                4: x = ~(a & b);    5: x = ~b;         6: x = a ^ b;    7: x = a & ~b;
                8: x = ~a | b;      9: x = ~(a ^ b);   10: x = b;       11: x = a & b;
                12: x = 8'hFF;      13: x = a | ~b;    14: x = a | b;   default: x = a;
            endcase
            return {1'b1, x};
        end
        case (s)
            0: begin x = a; y = 0; end
            1: begin x = a | b; y = 0; end
            2: begin x = a | ~b; y = 0; end
            3: begin x = 0; y = 8'hFF; end
            4: begin x = a; y = a & ~b; end
            5: begin x = a | b; y = a & ~b; end
            6: begin x = a; y = ~b; end
            7: begin x = a & ~b; y = 8'hFF; end
            8: begin x = a; y = a & b; end
            9: begin x = a; y = b; end
            10: begin x = a | ~b; y = a & b; end
            11: begin x = a & b; y = 8'hFF; end
            12: begin x = a; y = a; end
            13: begin x = a | b; y = a; end
            14: begin x = a | ~b; y = a; end
            default: begin x = a; y = 8'hFF; end
        endcase
        total = int'(x) + int'(y) + (cn ? 0 : 1);
        return {~(total > 255), 8'(total)};
    endfunction

    function automatic string auto_tag();
        if (!drive_en) return "R9";
        if (mode_logic) return "R3/R4";
        if (fsel == 4'b1001) return "R5";
        if (fsel == 4'b0110) return "R6";
        return "R7";
    endfunction

    task automatic compare(input string tag);
        logic [8:0] r;
        logic [7:0] exp_out;
        string t;
        r = ref_alu(ma, mb, fsel, mode_logic, cin_n);
        exp_out = drive_en ? r[7:0] : 8'h00;
        t = (tag == "") ? auto_tag() : tag;
        checks++;
        if (bus_out !== exp_out || bus_oe !== drive_en || cout_n !== r[8]) begin
            failures++;
            $display("FAIL %s: out=%h oe=%b cout_n=%b expected out=%h oe=%b cout_n=%b (A=%h B=%h s=%b m=%b cin_n=%b)",
                     t, bus_out, bus_oe, cout_n, exp_out, drive_en, r[8], ma, mb, fsel, mode_logic, cin_n);
        end
    endtask

    task automatic step(input logic [7:0] d, input logic la, input logic lb,
                        input logic [3:0] s, input logic m, input logic cn,
                        input logic oe, input string tag);
        @(negedge clk);
        bus_in = d; ld_a = la; ld_b = lb; fsel = s; mode_logic = m; cin_n = cn; drive_en = oe;
        #1 compare(tag);
        @(posedge clk);
        if (la) ma = d;
        if (lb) mb = d;
    endtask

    task automatic load(input logic [7:0] a, input logic [7:0] b);
        step(a, 1'b1, 1'b0, 4'b1111, 1'b1, 1'b1, 1'b1, "R1");
        step(b, 1'b0, 1'b1, 4'b1111, 1'b1, 1'b1, 1'b1, "R1");
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state (R2): operands zero, pass A and pass B read zero
        fsel = 4'b1111; mode_logic = 1'b1; drive_en = 1'b1;
        #7 compare("R2");
        fsel = 4'b1010; #1 compare("R2");
        @(negedge clk); rst_n = 1'b1;

        load(8'h3C, 8'hA5);
        for (int k = 0; k < 16; k++) begin
            step(8'h00, 0, 0, 4'(k), 1'b1, 1'b1, 1'b1, "");
            step(8'hFF, 0, 0, 4'(k), 1'b1, 1'b0, 1'b1, "R4");
            step(8'h00, 0, 0, 4'(k), 1'b0, 1'b1, 1'b1, "");
            step(8'h00, 0, 0, 4'(k), 1'b0, 1'b0, 1'b1, "");
        end

        // Hold check (R1): bus changes while strobes low
        step(8'h77, 0, 0, 4'b1111, 1'b1, 1'b1, 1'b1, "R1");
        step(8'h11, 0, 0, 4'b1010, 1'b1, 1'b1, 1'b1, "R1");

        // Ripple across nibbles (R8)
        load(8'h0F, 8'h01);
        step(8'h00, 0, 0, 4'b1001, 1'b0, 1'b1, 1'b1, "R8");
        load(8'hFF, 8'h01);
        step(8'h00, 0, 0, 4'b1001, 1'b0, 1'b1, 1'b1, "R8");
        step(8'h00, 0, 0, 4'b1001, 1'b0, 1'b0, 1'b1, "R8");
        // Subtraction borrow cases (R6)
        load(8'h10, 8'h20);
        step(8'h00, 0, 0, 4'b0110, 1'b0, 1'b0, 1'b1, "R6");
        load(8'h20, 8'h20);
        step(8'h00, 0, 0, 4'b0110, 1'b0, 1'b0, 1'b1, "R6");
        load(8'h81, 8'h7F);
        step(8'h00, 0, 0, 4'b0110, 1'b0, 1'b0, 1'b1, "R6");
        // Driver off (R9), then same-cycle response (R10)
        step(8'h00, 0, 0, 4'b1001, 1'b0, 1'b1, 1'b0, "R9");
        @(negedge clk);
        fsel = 4'b1100; mode_logic = 1'b0; cin_n = 1'b0; drive_en = 1'b1;
        #1 compare("R10");
        mode_logic = 1'b1; #1 compare("R10");

        // Mid-cycle clear (R2)
        @(negedge clk); #1;
        rst_n = 1'b0; ma = '0; mb = '0;
        fsel = 4'b1111; #1 compare("R2");
        fsel = 4'b1010; #1 compare("R2");
        @(negedge clk); rst_n = 1'b1;

        // Random mix
        for (int k = 0; k < 400; k++) begin
            step(8'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), "");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule